// File: doc/BRIEF.md
# Serial EEPROM Word Fetcher

This block reads a fixed run of 16-bit words from a three-wire serial EEPROM. The EEPROM has chip select, serial clock, data-in and data-out lines. A one-cycle start pulse launches the sequence. For each word the block first idles the bus, then clocks out a read opcode and the word address. It then clocks in the sixteen data bits. Each finished word goes into its own slot of an output register array, and a sticky done flag rises after the last word.

Every bus phase lasts a programmable number of system clocks. With the default of 50 000 clocks, a phase is 1 ms at 50 MHz. The first address, the number of words and the phase length are parameters. The address counts up by one per word and wraps modulo 32. The data-out line passes through a two-stage synchroniser before it is sampled.

Top module: `eeprom_word_fetch`

## Requirements
- R1: After reset, `eep_cs`, `eep_sck`, `eep_di`, `busy`, `done` and `word_valid` are low and every slot of `words` is zero.
- R2: A start pulse sampled while idle raises `busy` and clears `done` one cycle later. `busy` then stays high for exactly WORD_CNT × 74 × PHASE_CYC cycles (74 phases per word).
- R3: The serial clock is high only while chip select is high. Before each word's command, chip select is low for at least one phase.
- R4: After the bus idle, the block sends the opcode bits 1, 1, 0 in that order. It then sends the 5-bit word address, most significant bit first. Word i uses address (START_ADDR + i) mod 32.
- R5: Each outgoing bit takes three phases: data placed with the clock low, then the clock high for one phase, then the clock low again. Data-in does not change while the clock is high, nor in the cycle the clock falls.
- R6: Each of the 16 incoming bits holds the clock high for two phases, sampling data-out at the end of the second. The clock is then low for one phase. The first sampled bit becomes bit 15 of the word.
- R7: After the sixteenth data bit, chip select, clock and data-in all go low. Chip select falls exactly once per word.
- R8: When a word completes, `word_valid` pulses for one cycle with `word_idx` and `word_data`. Slot i of `words` (bits 16i+15 down to 16i) takes the value of word i.
- R9: `done` rises in the cycle in which `busy` falls after the last word. It stays high until the next accepted start, and it is low while `busy` is high.
- R10: A start pulse sampled while `busy` is high is ignored. This includes the cycle in which the last phase ends. Such a pulse changes neither the word count nor the busy duration.
- R11: With default parameters the run begins at word address 10 and fetches 3 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| eep_cs | output | 1 | EEPROM chip select, active high |
| eep_sck | output | 1 | EEPROM serial clock |
| eep_di | output | 1 | Serial data to the EEPROM |
| eep_do | input | 1 | Serial data from the EEPROM (asynchronous) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sticky completion flag |
| word_valid | output | 1 | One-cycle strobe for a finished word |
| word_idx | output | IDX_W | Slot index of the finished word |
| word_data | output | 16 | Value of the finished word |
| words | output | WORD_CNT×16 | All fetched words, slot i at bits 16i upward |

## Verification
Two events can fall in the same cycle: the end of the final phase, where `busy` falls and `done` rises, and a fresh start pulse. The bench issues a second start at offsets from two cycles before the end of a run to one cycle after it. It counts word strobes and busy cycles, and expects a second full run only when the start is sampled after the final edge. Start pulses placed inside a run must leave the strobe count and busy length unchanged. A bench-side EEPROM model decodes the opcode and the address and returns patterns computed from the address.

// File: rtl/eewf_pkg.sv
package eewf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RESET = 3'd1,
    ST_SEND  = 3'd2,
    ST_RECV  = 3'd3,
    ST_END   = 3'd4
  } seq_state_e;

  localparam int          OPCODE_W    = 3;
  localparam logic [2:0]  READ_OPCODE = 3'b110;
  localparam int          PH_PER_BIT  = 3;

  typedef struct packed {
    logic cs;
    logic sck;
    logic di;
  } bus_t;

endpackage

// File: rtl/eewf_phase_timer.sv
module eewf_phase_timer #(
  parameter int PHASE_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);

  localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = !hold && (cnt_q == CNT_LAST);
    cnt_d = (hold || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/eewf_sync.sv
module eewf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/eewf_seq.sv
module eewf_seq
  import eewf_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int WORD_CNT   = 3,
  parameter int START_ADDR = 10,
  parameter int IDX_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic              din_s,
  output logic              timer_hold,
  output logic              busy,
  output logic              done,
  output bus_t              bus,
  output logic              cap_valid,
  output logic [IDX_W-1:0]  cap_idx,
  output logic [DATA_W-1:0] cap_data
);

  localparam int TX_W  = OPCODE_W + ADDR_W;
  localparam int MAXB  = (DATA_W > TX_W) ? DATA_W : TX_W;
  localparam int BIT_W = (MAXB > 1) ? $clog2(MAXB) : 1;
  localparam logic [BIT_W-1:0]  TX_LAST    = BIT_W'(TX_W - 1);
  localparam logic [BIT_W-1:0]  RX_LAST    = BIT_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0]  IDX_LAST   = IDX_W'(WORD_CNT - 1);
  localparam logic [ADDR_W-1:0] ADDR_FIRST = ADDR_W'(START_ADDR);
  localparam logic [1:0]        PH_LAST    = 2'(PH_PER_BIT - 1);

  seq_state_e        state_q, state_d;
  logic [1:0]        ph_q, ph_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [TX_W-1:0]   tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic              capv_q, capv_d;
  logic [IDX_W-1:0]  capi_q, capi_d;
  logic [DATA_W-1:0] capd_q, capd_d;
  bus_t              bus_q, bus_d;
  logic              ph_end;

  assign ph_end = (ph_q == PH_LAST);

  // next-state process
  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    bit_d   = bit_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    idx_d   = idx_q;
    addr_d  = addr_q;
    done_d  = done_q;
    capv_d  = 1'b0;
    capi_d  = capi_q;
    capd_d  = capd_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RESET;
          idx_d   = '0;
          addr_d  = ADDR_FIRST;
          done_d  = 1'b0;
        end
      end
      ST_RESET: begin
        if (tick) begin
          state_d = ST_SEND;
          ph_d    = '0;
          bit_d   = '0;
          tx_d    = {READ_OPCODE, addr_q};
        end
      end
      ST_SEND: begin
        if (tick) begin
          if (ph_end) begin
            ph_d = '0;
            tx_d = {tx_q[TX_W-2:0], 1'b0};
            if (bit_q == TX_LAST) begin
              state_d = ST_RECV;
              bit_d   = '0;
              rx_d    = '0;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      ST_RECV: begin
        if (tick) begin
          if (ph_q == 2'd1) rx_d = {rx_q[DATA_W-2:0], din_s};
          if (ph_end) begin
            ph_d = '0;
            if (bit_q == RX_LAST) begin
              state_d = ST_END;
              capv_d  = 1'b1;
              capi_d  = idx_q;
              capd_d  = rx_q;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      ST_END: begin
        if (tick) begin
          if (idx_q == IDX_LAST) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_RESET;
            idx_d   = idx_q + 1'b1;
            addr_d  = addr_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // pin decode, registered below so every pin moves one cycle after its phase
  always_comb begin
    bus_d = '0;
    unique case (state_q)
      ST_SEND: begin
        bus_d.cs  = 1'b1;
        bus_d.sck = (ph_q == 2'd1);
        bus_d.di  = tx_q[TX_W-1];
      end
      ST_RECV: begin
        bus_d.cs  = 1'b1;
        bus_d.sck = !ph_end;
        bus_d.di  = 1'b0;
      end
      default: bus_d = '0;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      capv_q  <= 1'b0;
      capi_q  <= '0;
      capd_q  <= '0;
      bus_q   <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      idx_q   <= idx_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
      capv_q  <= capv_d;
      capi_q  <= capi_d;
      capd_q  <= capd_d;
      bus_q   <= bus_d;
    end
  end

  assign timer_hold = (state_q == ST_IDLE);
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign bus        = bus_q;
  assign cap_valid  = capv_q;
  assign cap_idx    = capi_q;
  assign cap_data   = capd_q;

endmodule

// File: rtl/eewf_word_store.sv
module eewf_word_store #(
  parameter int DATA_W   = 16,
  parameter int WORD_CNT = 3,
  parameter int IDX_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [WORD_CNT*DATA_W-1:0] words
);

  generate
    for (genvar g = 0; g < WORD_CNT; g++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      logic              slot_en;

      assign slot_en = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       slot_q <= '0;
        else if (slot_en) slot_q <= wr_data;
      end

      assign words[g*DATA_W +: DATA_W] = slot_q;
    end
  endgenerate

endmodule

// File: rtl/eeprom_word_fetch.sv
module eeprom_word_fetch
  import eewf_pkg::*;
#(
  parameter int PHASE_CYC  = 50000,
  parameter int START_ADDR = 10,
  parameter int WORD_CNT   = 3,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int SYNC_STG   = 2,
  localparam int IDX_W     = (WORD_CNT > 1) ? $clog2(WORD_CNT) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  output logic                       eep_cs,
  output logic                       eep_sck,
  output logic                       eep_di,
  input  logic                       eep_do,
  output logic                       busy,
  output logic                       done,
  output logic                       word_valid,
  output logic [IDX_W-1:0]           word_idx,
  output logic [DATA_W-1:0]          word_data,
  output logic [WORD_CNT*DATA_W-1:0] words
);

  logic tick;
  logic timer_hold;
  logic din_s;
  bus_t bus;

  eewf_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (timer_hold),
    .tick  (tick)
  );

  eewf_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (eep_do),
    .q_sync  (din_s)
  );

  eewf_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .WORD_CNT   (WORD_CNT),
    .START_ADDR (START_ADDR),
    .IDX_W      (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .tick       (tick),
    .din_s      (din_s),
    .timer_hold (timer_hold),
    .busy       (busy),
    .done       (done),
    .bus        (bus),
    .cap_valid  (word_valid),
    .cap_idx    (word_idx),
    .cap_data   (word_data)
  );

  eewf_word_store #(
    .DATA_W   (DATA_W),
    .WORD_CNT (WORD_CNT),
    .IDX_W    (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (word_valid),
    .wr_idx  (word_idx),
    .wr_data (word_data),
    .words   (words)
  );

  assign eep_cs  = bus.cs;
  assign eep_sck = bus.sck;
  assign eep_di  = bus.di;

endmodule

// File: rtl/eewf_checker.sv
module eewf_checker #(
  parameter int PHASE_CYC = 50000,
  parameter int WORD_CNT  = 3,
  parameter int IDX_W     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             eep_cs,
  input logic             eep_sck,
  input logic             eep_di,
  input logic             busy,
  input logic             done,
  input logic             word_valid,
  input logic [IDX_W-1:0] word_idx
);

  logic [31:0] hi_run_q;
  logic [31:0] lo_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= '0;
      lo_run_q <= '0;
    end else begin
      hi_run_q <= eep_sck ? hi_run_q + 1 : '0;
      if (eep_cs)                       lo_run_q <= '0;
      else if (lo_run_q < PHASE_CYC)    lo_run_q <= lo_run_q + 1;
    end
  end

  assert_sck_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eep_sck |-> eep_cs);

  assert_idle_before_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eep_cs) |-> (lo_run_q >= PHASE_CYC));

  assert_di_held_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eep_sck && $past(eep_sck)) |-> $stable(eep_di));

  assert_di_held_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eep_sck) |-> $stable(eep_di));

  assert_clock_high_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eep_sck) |-> (hi_run_q == PHASE_CYC || hi_run_q == 2 * PHASE_CYC));

  assert_cs_drop_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eep_cs) |-> !eep_sck);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  assert_strobe_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (word_idx <= IDX_W'(WORD_CNT - 1)));

  assert_done_on_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  assert_done_low_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

endmodule

bind eeprom_word_fetch eewf_checker #(
  .PHASE_CYC (PHASE_CYC),
  .WORD_CNT  (WORD_CNT),
  .IDX_W     (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .eep_cs     (eep_cs),
  .eep_sck    (eep_sck),
  .eep_di     (eep_di),
  .busy       (busy),
  .done       (done),
  .word_valid (word_valid),
  .word_idx   (word_idx)
);

// File: tb/tb_eeprom_word_fetch.sv
module tb_eeprom_model (
  input  logic        cs,
  input  logic        sck,
  input  logic        di,
  input  logic [15:0] seed,
  output logic        dout,
  output logic [4:0]  last_addr,
  output logic        cmd_ok
);

  int          bitcnt = 0;
  logic [7:0]  rx_r   = '0;
  logic [15:0] word_r = '0;
  logic        dout_r = 1'b0;
  logic [4:0]  addr_r = '0;
  logic        ok_r   = 1'b0;

  function automatic logic [15:0] pat(input logic [4:0] a, input logic [15:0] s);
    return (16'(a) * 16'h0841) ^ s ^ 16'h5A3C;
  endfunction

  always @(posedge sck or negedge cs) begin
    if (!cs) begin
      bitcnt <= 0;
      dout_r <= 1'b0;
    end else begin
      if (bitcnt < 8) begin
        rx_r <= {rx_r[6:0], di};
        if (bitcnt == 7) begin
          ok_r   <= (rx_r[6:4] == 3'b110);
          addr_r <= {rx_r[3:0], di};
          word_r <= pat({rx_r[3:0], di}, seed);
        end
      end else if (bitcnt < 24) begin
        dout_r <= word_r[23 - bitcnt];
      end
      bitcnt <= bitcnt + 1;
    end
  end

  assign dout      = dout_r;
  assign last_addr = addr_r;
  assign cmd_ok    = ok_r;

endmodule

module tb_eeprom_word_fetch;

  localparam int P  = 2;
  localparam int S0 = 10;
  localparam int C0 = 3;
  localparam int S1 = 31;
  localparam int C1 = 2;
  localparam int T0 = C0 * 74 * P;
  localparam int T1 = C1 * 74 * P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start0 = 1'b0;
  logic start1 = 1'b0;
  logic [15:0] seed = 16'h1234;

  always #10 clk = ~clk;

  logic        cs0, sck0, di0, do0, busy0, done0, wv0;
  logic [1:0]  wi0;
  logic [15:0] wd0;
  logic [47:0] words0;
  logic [4:0]  ma0;
  logic        mok0;

  logic        cs1, sck1, di1, do1, busy1, done1, wv1;
  logic [0:0]  wi1;
  logic [15:0] wd1;
  logic [31:0] words1;
  logic [4:0]  ma1;
  logic        mok1;

  eeprom_word_fetch #(.PHASE_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .start(start0),
    .eep_cs(cs0), .eep_sck(sck0), .eep_di(di0), .eep_do(do0),
    .busy(busy0), .done(done0), .word_valid(wv0), .word_idx(wi0),
    .word_data(wd0), .words(words0)
  );

  eeprom_word_fetch #(.PHASE_CYC(P), .START_ADDR(S1), .WORD_CNT(C1)) dut_wrap (
    .clk(clk), .rst_n(rst_n), .start(start1),
    .eep_cs(cs1), .eep_sck(sck1), .eep_di(di1), .eep_do(do1),
    .busy(busy1), .done(done1), .word_valid(wv1), .word_idx(wi1),
    .word_data(wd1), .words(words1)
  );

  tb_eeprom_model u_mem0 (.cs(cs0), .sck(sck0), .di(di0), .seed(seed),
                          .dout(do0), .last_addr(ma0), .cmd_ok(mok0));
  tb_eeprom_model u_mem1 (.cs(cs1), .sck(sck1), .di(di1), .seed(seed),
                          .dout(do1), .last_addr(ma1), .cmd_ok(mok1));

  function automatic logic [15:0] pat(input logic [4:0] a, input logic [15:0] s);
    return (16'(a) * 16'h0841) ^ s ^ 16'h5A3C;
  endfunction

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // strobe monitors (R4, R6, R8, R11)
  int m0_str = 0, m0_chk = 0, m0_err = 0;
  int m1_str = 0, m1_chk = 0, m1_err = 0;

  always @(negedge clk) begin
    if (rst_n && wv0) begin
      automatic int       ei = m0_str % C0;
      automatic logic [4:0] ea = 5'(S0 + ei);
      m0_chk += 3;
      if (int'(wi0) != ei) begin
        m0_err++; $display("FAIL R8 index actual=%0d expected=%0d", wi0, ei);
      end
      if (wd0 != pat(ea, seed)) begin
        m0_err++; $display("FAIL R6 data actual=%0h expected=%0h", wd0, pat(ea, seed));
      end
      if (!(mok0 && ma0 == ea)) begin
        m0_err++; $display("FAIL R4 cmd/addr actual=%0h expected=%0h", {mok0, ma0}, {1'b1, ea});
      end
      m0_str++;
    end
    if (rst_n && wv1) begin
      automatic int       ei = m1_str % C1;
      automatic logic [4:0] ea = 5'(S1 + ei);
      m1_chk += 3;
      if (int'(wi1) != ei) begin
        m1_err++; $display("FAIL R8 wrap index actual=%0d expected=%0d", wi1, ei);
      end
      if (wd1 != pat(ea, seed)) begin
        m1_err++; $display("FAIL R6 wrap data actual=%0h expected=%0h", wd1, pat(ea, seed));
      end
      if (!(mok1 && ma1 == ea)) begin
        m1_err++; $display("FAIL R4 wrap addr actual=%0h expected=%0h", {mok1, ma1}, {1'b1, ea});
      end
      m1_str++;
    end
  end

  // bus shape and busy length counters
  int bcnt0 = 0, bcnt1 = 0;
  int hrun = 0, hshort = 0, hlong = 0, hbad = 0, csfall = 0;
  logic cs0_prev = 1'b0;

  always @(negedge clk) begin
    if (busy0) bcnt0++;
    if (busy1) bcnt1++;
    if (sck0) hrun++;
    else if (hrun != 0) begin
      if (hrun == P) hshort++;
      else if (hrun == 2 * P) hlong++;
      else hbad++;
      hrun = 0;
    end
    if (cs0_prev && !cs0) csfall++;
    cs0_prev = cs0;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks",
               errors + m0_err + m1_err + 1, checks + m0_chk + m1_chk + 1);
      $finish;
    end
  end

  initial begin
    int s_str0, s_str1, s_b0, s_b1, s_hs, s_hl, s_hb, s_cf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({cs0, sck0, di0, busy0, done0, wv0} == 6'b0, "R1 pins/flags", {cs0, sck0, di0, busy0, done0, wv0}, 0);
    chk(words0 == '0 && words1 == '0, "R1 slots", words0, 0);

    // run 1: both instances
    s_str0 = m0_str; s_str1 = m1_str; s_b0 = bcnt0; s_b1 = bcnt1;
    s_hs = hshort; s_hl = hlong; s_hb = hbad; s_cf = csfall;
    start0 = 1'b1; start1 = 1'b1;
    @(negedge clk);
    start0 = 1'b0; start1 = 1'b0;
    chk(busy0 && !done0 && busy1, "R2 accept", {busy0, done0, busy1}, 3'b101);
    repeat (T0 + 10) @(negedge clk);
    chk(bcnt0 - s_b0 == T0, "R2 busy length", bcnt0 - s_b0, T0);
    chk(bcnt1 - s_b1 == T1, "R2 wrap busy length", bcnt1 - s_b1, T1);
    chk(done0 && done1, "R9 done raised", {done0, done1}, 2'b11);
    chk(m0_str - s_str0 == C0, "R11 word count", m0_str - s_str0, C0);
    chk(m1_str - s_str1 == C1, "R8 wrap word count", m1_str - s_str1, C1);
    for (int i = 0; i < C0; i++)
      chk(words0[i*16 +: 16] == pat(5'(S0 + i), seed), "R11 slot value",
          words0[i*16 +: 16], pat(5'(S0 + i), seed));
    chk(words1[15:0] == pat(5'd31, seed) && words1[31:16] == pat(5'd0, seed),
        "R4 address wrap", words1, {pat(5'd0, seed), pat(5'd31, seed)});
    chk(hshort - s_hs == C0 * 8, "R5 outgoing clock pulses", hshort - s_hs, C0 * 8);
    chk(hlong - s_hl == C0 * 16, "R6 incoming clock pulses", hlong - s_hl, C0 * 16);
    chk(hbad == s_hb, "R6 odd clock pulses", hbad - s_hb, 0);
    chk(csfall - s_cf == C0, "R7 select drops", csfall - s_cf, C0);
    chk({cs0, sck0, di0} == 3'b0, "R7 bus idle", {cs0, sck0, di0}, 0);

    // R9 sticky
    repeat (50) @(negedge clk);
    chk(done0 && !busy0, "R9 sticky", {done0, busy0}, 2'b10);

    // run 2 with new pattern, start pulses inside the run (R10)
    seed = 16'hBEEF;
    s_str0 = m0_str; s_b0 = bcnt0;
    start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    chk(!done0 && busy0, "R9 done cleared", {done0, busy0}, 2'b01);
    for (int k = 0; k < 3; k++) begin
      repeat (120) @(negedge clk);
      start0 = 1'b1;
      @(negedge clk);
      start0 = 1'b0;
    end
    repeat (T0) @(negedge clk);
    chk(m0_str - s_str0 == C0, "R10 ignored start words", m0_str - s_str0, C0);
    chk(bcnt0 - s_b0 == T0, "R10 ignored start length", bcnt0 - s_b0, T0);
    for (int i = 0; i < C0; i++)
      chk(words0[i*16 +: 16] == pat(5'(S0 + i), seed), "R8 slot second pattern",
          words0[i*16 +: 16], pat(5'(S0 + i), seed));

    // R9/R10 collision sweep around the final edge
    for (int d = T0 - 2; d <= T0 + 1; d++) begin
      automatic int exp_w = (d >= T0) ? 2 * C0 : C0;
      automatic int exp_b = (d >= T0) ? 2 * T0 : T0;
      s_str0 = m0_str; s_b0 = bcnt0;
      start0 = 1'b1;
      @(negedge clk);
      start0 = 1'b0;
      repeat (d) @(negedge clk);
      start0 = 1'b1;
      @(negedge clk);
      start0 = 1'b0;
      repeat (2 * T0 + 20) @(negedge clk);
      chk(m0_str - s_str0 == exp_w, "R10 edge sweep words", m0_str - s_str0, exp_w);
      chk(bcnt0 - s_b0 == exp_b, "R9 edge sweep length", bcnt0 - s_b0, exp_b);
      chk(done0 && !busy0, "R9 edge sweep done", {done0, busy0}, 2'b10);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks",
             errors + m0_err + m1_err, checks + m0_chk + m1_chk);
    $finish;
  end

endmodule